// File: doc/BRIEF.md
# Flash Program/Erase Protection Gate

This block sits between a command source and a flash array. It takes page-write and row-erase commands. Each command address is aligned to the granule of its operation, and the block then decides whether the target may be altered. A row is 256 bytes and holds four 64-byte pages. An erase touches a whole row and a write touches one page. The array is split into sixteen equal regions, and each region has its own lock bit. A protected boot area can also be reserved at the bottom of the array. Both the region size and the boot area size come from a configuration word that is loaded once after reset. No command is taken before that word arrives.

A command that clears every check goes to the array as a one-cycle request. The block then waits for the array to report completion and pulses a cache-invalidate request. A command that hits a locked region, the boot area or an address past the end of the array is dropped. Dropping it sets a sticky lock-error flag. A command that arrives while an earlier one is still being handled is also dropped, and it sets a sticky programming-error flag.

The sequencer has six states:
- **CFG**: wait for configuration. It moves to IDLE once the configuration is latched.
- **IDLE**: moves to CHECK when a command arrives.
- **CHECK**: moves to IDLE if the command is blocked, or to ISSUE if it is allowed.
- **ISSUE**: drives the array request, then moves to WAIT.
- **WAIT**: moves to DONE when the array reports done.
- **DONE**: drives the invalidate pulse, then moves to IDLE.

Top module: `flash_guard`

## Requirements
- R1: After reset, `cfg_ready` is 0 and commands are ignored, with no flag and no array request. The first `cfg_valid` pulse latches `cfg_size` and `cfg_bootprot` and raises `cfg_ready`. Any later `cfg_valid` is ignored until the next reset.
- R2: The array size follows `cfg_size`: 0 gives 16 KB, 1 gives 32 KB, and 2 or 3 give 64 KB. Each of the 16 regions is one sixteenth of the array. The region index is the aligned address divided by the region size, so with 16 KB, address 0x0C00 lies in region 3.
- R3: `cmd_op` 0 is a page write and 1 is a row erase. An accepted erase shows its address on `arr_addr` rounded down to a multiple of 256. An accepted write rounds down to a multiple of 64. `arr_op` repeats `cmd_op`.
- R4: If `lock_bits[i]` is 1, every write and every erase aiming at region i is blocked. A blocked command raises `lock_err` and produces no `arr_req`. The same command goes through once the bit is 0.
- R5: Addresses below `cfg_bootprot` × 1024 bytes are blocked in the same way as a locked region, for both operations.
- R6: An aligned address at or beyond the array size is blocked and raises `lock_err`. The last row of the array is still accepted.
- R7: A command accepted at clock edge E appears as a one-cycle `arr_req` in the cycle after edge E+1. `busy` is 1 from edge E until the invalidate cycle has ended. A blocked command sets `lock_err` at edge E+1 and leaves `busy` 0 from then on.
- R8: After `arr_done` is sampled high, `cache_inval` is high for exactly one cycle and the block then returns to idle.
- R9: A command presented while `busy` is 1 never reaches the array and sets `prog_err`. This includes the invalidate cycle.
- R10: `err_clr` clears `lock_err` and `prog_err`. If a flag's set condition occurs in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configuration word strobe |
| cfg_size | input | 2 | Array size code |
| cfg_bootprot | input | 4 | Boot area size in 1 KB units |
| cfg_ready | output | 1 | Configuration has been latched |
| lock_bits | input | 16 | Per-region lock bits |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 1 | 0 = page write, 1 = row erase |
| cmd_addr | input | 16 | Command byte address |
| err_clr | input | 1 | Clear sticky error flags |
| busy | output | 1 | Command in progress |
| lock_err | output | 1 | Sticky protection violation flag |
| prog_err | output | 1 | Sticky command-while-busy flag |
| arr_req | output | 1 | One-cycle array operation request |
| arr_op | output | 1 | Operation of the request |
| arr_addr | output | 16 | Aligned address of the request |
| arr_done | input | 1 | Array operation finished |
| cache_inval | output | 1 | One-cycle cache invalidate request |

## Verification
Completion of an accepted operation and the arrival of a new command can land in the same cycle. To provoke this, the bench drives a fresh command exactly in the cycle where `cache_inval` is high. It then judges that `prog_err` rises, that no second array request appears and that the invalidate stays a single pulse. A second collision pairs `err_clr` with a busy-time command in the same cycle, and the flag is expected to stay set. A scoreboard holds every expected array request and lock error in order, so any extra or missing event is caught.

// File: rtl/flc_pkg.sv
package flc_pkg;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_ERASE = 1'b1
    } flc_op_e;

    typedef enum logic [2:0] {
        S_CFG,
        S_IDLE,
        S_CHECK,
        S_ISSUE,
        S_WAIT,
        S_DONE
    } flc_state_e;

endpackage

// File: rtl/flc_boot_cfg.sv
module flc_boot_cfg #(
    parameter int ADDR_W   = 16,
    parameter int SIZE_W   = 2,
    parameter int BP_W     = 4,
    parameter int BP_UNIT  = 10,
    parameter int LOG_W    = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [BP_W-1:0]   cfg_bootprot,
    output logic              cfg_ready,
    output logic [LOG_W-1:0]  array_log2,
    output logic [ADDR_W:0]   boot_limit
);

    localparam int MAX_CODE = 2;

    logic [SIZE_W-1:0] size_q;
    logic [BP_W-1:0]   bp_q;
    logic [SIZE_W-1:0] size_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_ready <= 1'b0;
            size_q    <= '0;
            bp_q      <= '0;
        end else if (cfg_valid && !cfg_ready) begin
            cfg_ready <= 1'b1;
            size_q    <= cfg_size;
            bp_q      <= cfg_bootprot;
        end
    end

    always_comb begin
        size_eff = (size_q > SIZE_W'(MAX_CODE)) ? SIZE_W'(MAX_CODE) : size_q;
        array_log2 = LOG_W'(ADDR_W - MAX_CODE) + LOG_W'(size_eff);
        boot_limit = (ADDR_W + 1)'(bp_q) << BP_UNIT;
    end

endmodule

// File: rtl/flc_lock_check.sv
module flc_lock_check
    import flc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int REGIONS   = 16,
    parameter int ROW_LOG2  = 8,
    parameter int PAGE_LOG2 = 6,
    parameter int LOG_W     = $clog2(ADDR_W + 1)
) (
    input  flc_op_e             op,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [LOG_W-1:0]    array_log2,
    input  logic [ADDR_W:0]     boot_limit,
    input  logic [REGIONS-1:0]  lock_bits,
    output logic [ADDR_W-1:0]   aligned,
    output logic                blocked
);

    localparam int RIDX_W = $clog2(REGIONS);

    logic [ADDR_W-1:0] shifted;
    logic [RIDX_W-1:0] region;
    logic [ADDR_W:0]   array_end;
    logic              out_of_range;
    logic              in_boot;

    always_comb begin
        if (op == OP_ERASE)
            aligned = {addr[ADDR_W-1:ROW_LOG2], {ROW_LOG2{1'b0}}};
        else
            aligned = {addr[ADDR_W-1:PAGE_LOG2], {PAGE_LOG2{1'b0}}};

        array_end    = (ADDR_W + 1)'(1) << array_log2;
        out_of_range = {1'b0, aligned} >= array_end;
        in_boot      = {1'b0, aligned} < boot_limit;
        shifted      = aligned >> (array_log2 - LOG_W'(RIDX_W));
        region       = shifted[RIDX_W-1:0];
        blocked      = out_of_range || in_boot || lock_bits[region];
    end

endmodule

// File: rtl/flc_seq.sv
module flc_seq
    import flc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ready,
    input  logic              cmd_valid,
    input  flc_op_e           cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              blocked,
    input  logic              err_clr,
    input  logic              arr_done,
    output flc_op_e           lat_op,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              busy,
    output logic              arr_req,
    output logic              cache_inval,
    output logic              lock_err,
    output logic              prog_err
);

    flc_state_e state_q, state_d;
    logic       accept, reject, lock_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_CFG;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_CFG:   if (cfg_ready) state_d = S_IDLE;
            S_IDLE:  if (cmd_valid) state_d = S_CHECK;
            S_CHECK: state_d = blocked ? S_IDLE : S_ISSUE;
            S_ISSUE: state_d = S_WAIT;
            S_WAIT:  if (arr_done) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_CFG;
        endcase
    end

    always_comb begin
        busy        = 1'b0;
        arr_req     = 1'b0;
        cache_inval = 1'b0;
        unique case (state_q)
            S_CFG, S_IDLE: busy = 1'b0;
            S_CHECK:       busy = 1'b1;
            S_ISSUE: begin busy = 1'b1; arr_req = 1'b1; end
            S_WAIT:        busy = 1'b1;
            S_DONE:  begin busy = 1'b1; cache_inval = 1'b1; end
            default:       busy = 1'b0;
        endcase
        accept   = (state_q == S_IDLE) && cmd_valid;
        reject   = busy && cmd_valid;
        lock_hit = (state_q == S_CHECK) && blocked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_op   <= OP_WRITE;
            lat_addr <= '0;
            lock_err <= 1'b0;
            prog_err <= 1'b0;
        end else begin
            if (accept) begin
                lat_op   <= cmd_op;
                lat_addr <= cmd_addr;
            end
            if (lock_hit)     lock_err <= 1'b1;
            else if (err_clr) lock_err <= 1'b0;
            if (reject)       prog_err <= 1'b1;
            else if (err_clr) prog_err <= 1'b0;
        end
    end

    a_r1_idle_until_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ready |-> !busy);
    a_r7_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |=> (!arr_req && busy));
    a_r8_inval_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cache_inval |=> (!cache_inval && !busy));
    a_r9_busy_cmd_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> prog_err);
    a_r10_clear_wins_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !(busy && cmd_valid)) |=> !prog_err);

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int REGIONS   = 16,
    parameter int ROW_LOG2  = 8,
    parameter int PAGE_LOG2 = 6,
    parameter int SIZE_W    = 2,
    parameter int BP_W      = 4,
    parameter int BP_UNIT   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [BP_W-1:0]   cfg_bootprot,
    output logic              cfg_ready,
    input  logic [REGIONS-1:0] lock_bits,
    input  logic              cmd_valid,
    input  logic              cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              err_clr,
    output logic              busy,
    output logic              lock_err,
    output logic              prog_err,
    output logic              arr_req,
    output logic              arr_op,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic              arr_done,
    output logic              cache_inval
);

    localparam int LOG_W = $clog2(ADDR_W + 1);

    logic [LOG_W-1:0]  array_log2;
    logic [ADDR_W:0]   boot_limit;
    flc_op_e           lat_op;
    logic [ADDR_W-1:0] lat_addr;
    logic              blocked;

    flc_boot_cfg #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BP_W(BP_W),
        .BP_UNIT(BP_UNIT), .LOG_W(LOG_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid),
        .cfg_size(cfg_size), .cfg_bootprot(cfg_bootprot),
        .cfg_ready(cfg_ready), .array_log2(array_log2),
        .boot_limit(boot_limit)
    );

    flc_lock_check #(
        .ADDR_W(ADDR_W), .REGIONS(REGIONS), .ROW_LOG2(ROW_LOG2),
        .PAGE_LOG2(PAGE_LOG2), .LOG_W(LOG_W)
    ) u_chk (
        .op(lat_op), .addr(lat_addr), .array_log2(array_log2),
        .boot_limit(boot_limit), .lock_bits(lock_bits),
        .aligned(arr_addr), .blocked(blocked)
    );

    flc_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cfg_ready(cfg_ready),
        .cmd_valid(cmd_valid), .cmd_op(flc_op_e'(cmd_op)),
        .cmd_addr(cmd_addr), .blocked(blocked), .err_clr(err_clr),
        .arr_done(arr_done), .lat_op(lat_op), .lat_addr(lat_addr),
        .busy(busy), .arr_req(arr_req), .cache_inval(cache_inval),
        .lock_err(lock_err), .prog_err(prog_err)
    );

    assign arr_op = lat_op;

    a_r3_aligned_request: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |-> (arr_op ? (arr_addr[ROW_LOG2-1:0] == '0)
                            : (arr_addr[PAGE_LOG2-1:0] == '0)));
    a_r5_boot_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |-> ({1'b0, arr_addr} >= boot_limit));
    a_r6_inside_array: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |-> ({1'b0, arr_addr} < ((ADDR_W + 1)'(1) << array_log2)));

endmodule

// File: tb/flash_guard_test.sv
module flash_guard_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic [1:0]  cfg_size = '0;
    logic [3:0]  cfg_bootprot = '0;
    logic        cfg_ready;
    logic [15:0] lock_bits = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_op = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic        err_clr = 1'b0;
    logic        busy, lock_err, prog_err, arr_req, arr_op, cache_inval;
    logic [15:0] arr_addr;
    logic        arr_done = 1'b0;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    // expected item: {is_err, op, addr}
    logic [17:0] exp_q[$];

    always #2 clk = ~clk;

    flash_guard uut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_size(cfg_size),
        .cfg_bootprot(cfg_bootprot), .cfg_ready(cfg_ready), .lock_bits(lock_bits),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .err_clr(err_clr), .busy(busy), .lock_err(lock_err), .prog_err(prog_err),
        .arr_req(arr_req), .arr_op(arr_op), .arr_addr(arr_addr),
        .arr_done(arr_done), .cache_inval(cache_inval)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // array model: completes a request a few cycles later
    initial forever begin
        @(negedge clk);
        if (arr_req) begin
            repeat (2) @(negedge clk);
            arr_done = 1'b1;
            @(negedge clk);
            arr_done = 1'b0;
        end
    end

    // monitor: compares array requests and lock errors against the queue
    initial begin
        logic lock_prev = 1'b0;
        logic [17:0] item;
        forever begin
            @(negedge clk);
            #1;
            if (!rst_n) begin
                lock_prev = 1'b0;
            end else begin
                if (arr_req) begin
                    if (exp_q.size() == 0)
                        check(0, "R4 unexpected arr_req", int'(arr_addr), 0);
                    else begin
                        item = exp_q.pop_front();
                        check(!item[17] && item[16] == arr_op && item[15:0] == arr_addr,
                              "R3 array request", int'({arr_op, arr_addr}), int'(item[16:0]));
                    end
                end
                if (lock_err && !lock_prev) begin
                    if (exp_q.size() == 0)
                        check(0, "R4 unexpected lock_err", 1, 0);
                    else begin
                        item = exp_q.pop_front();
                        check(item[17], "R4 lock error expected", 1, int'(item[17]));
                    end
                end
                lock_prev = lock_err;
            end
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr;
        err_clr = 1'b1;
        tick();
        err_clr = 1'b0;
    endtask

    task automatic do_reset(input logic [1:0] sz, input logic [3:0] bp);
        rst_n = 1'b0;
        exp_q.delete();
        tick(3);
        rst_n = 1'b1;
        tick(2);
        check(!cfg_ready && !busy && !lock_err && !prog_err && !arr_req,
              "R1 reset state", int'({cfg_ready, busy, lock_err, prog_err}), 0);
        cfg_size = sz;
        cfg_bootprot = bp;
        cfg_valid = 1'b1;
        tick();
        cfg_valid = 1'b0;
        tick(2);
        check(cfg_ready, "R1 config latched", int'(cfg_ready), 1);
    endtask

    task automatic wait_inval(input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 40 && !seen; i++) begin
            tick();
            if (cache_inval) seen = 1'b1;
        end
        check(seen, req, int'(seen), 1);
    endtask

    // drive one command; ok says whether an array op is expected
    task automatic do_cmd(input logic op, input logic [15:0] addr, input bit ok,
                          input logic [15:0] exp_addr, input string req);
        exp_q.push_back({!ok, op, ok ? exp_addr : 16'h0});
        cmd_op = op;
        cmd_addr = addr;
        cmd_valid = 1'b1;
        tick();
        cmd_valid = 1'b0;
        tick();
        if (ok) begin
            wait_inval({req, " R8 invalidate after completion"});
            tick();
            check(!busy && !cache_inval, "R8 back to idle", int'({busy, cache_inval}), 0);
        end else begin
            check(lock_err && !busy, req, int'({lock_err, busy}), 2);
            pulse_clr();
            check(!lock_err, "R10 lock_err cleared", int'(lock_err), 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // configuration A: 64 KB, 4 KB regions, 2 KB boot area, region 1 locked
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        check(!cfg_ready && !busy && !lock_err && !prog_err,
              "R1 reset state", int'({cfg_ready, busy, lock_err, prog_err}), 0);
        // R1: command before configuration is ignored
        cmd_op = 1'b0; cmd_addr = 16'h3000; cmd_valid = 1'b1;
        tick(); cmd_valid = 1'b0;
        tick(4);
        check(!busy && !prog_err && !lock_err, "R1 pre-config command ignored",
              int'({busy, prog_err, lock_err}), 0);
        lock_bits = 16'h0002;
        cfg_size = 2'd2; cfg_bootprot = 4'd2; cfg_valid = 1'b1;
        tick(); cfg_valid = 1'b0;
        tick(2);
        check(cfg_ready, "R1 config latched", int'(cfg_ready), 1);
        // R1: a second config word must be ignored
        cfg_bootprot = 4'd0; cfg_valid = 1'b1;
        tick(); cfg_valid = 1'b0;
        tick();

        // R7 timing on a write
        exp_q.push_back({1'b0, 1'b0, 16'h30C0});
        cmd_op = 1'b0; cmd_addr = 16'h30F7; cmd_valid = 1'b1;
        tick(); cmd_valid = 1'b0;
        check(busy && !arr_req, "R7 busy before request", int'({busy, arr_req}), 2);
        tick();
        check(arr_req && busy, "R7 request cycle", int'({arr_req, busy}), 3);
        wait_inval("R8 invalidate after write");
        tick();
        check(!busy, "R7 busy drops after invalidate", int'(busy), 0);

        do_cmd(1'b1, 16'h30F7, 1'b1, 16'h3000, "R3 erase aligned to row");
        do_cmd(1'b0, 16'h12F7, 1'b0, 16'h0, "R4 write into locked region");
        do_cmd(1'b1, 16'h1000, 1'b0, 16'h0, "R4 erase into locked region");
        do_cmd(1'b0, 16'h0400, 1'b0, 16'h0, "R5 write in boot area (R1 second cfg ignored)");
        do_cmd(1'b1, 16'h07FF, 1'b0, 16'h0, "R5 erase in boot area");
        do_cmd(1'b0, 16'h0800, 1'b1, 16'h0800, "R5 first page past boot area");
        lock_bits = 16'h0000;
        do_cmd(1'b0, 16'h12F7, 1'b1, 16'h12C0, "R4 unlocked region accepted");

        // R9: command during WAIT is dropped
        exp_q.push_back({1'b0, 1'b1, 16'h4000});
        cmd_op = 1'b1; cmd_addr = 16'h4010; cmd_valid = 1'b1;
        tick(); cmd_valid = 1'b0;
        tick(2);
        cmd_op = 1'b0; cmd_addr = 16'h5000; cmd_valid = 1'b1;
        tick(); cmd_valid = 1'b0;
        check(prog_err, "R9 command while busy flagged", int'(prog_err), 1);
        wait_inval("R8 invalidate after erase");
        tick(3);
        check(exp_q.size() == 0 && !busy, "R9 dropped command not issued",
              exp_q.size(), 0);
        pulse_clr();
        check(!prog_err, "R10 prog_err cleared", int'(prog_err), 0);

        // R9: command coinciding with the invalidate cycle
        exp_q.push_back({1'b0, 1'b0, 16'h6000});
        cmd_op = 1'b0; cmd_addr = 16'h6000; cmd_valid = 1'b1;
        tick(); cmd_valid = 1'b0;
        for (int i = 0; i < 40 && !cache_inval; i++) tick();
        cmd_op = 1'b1; cmd_addr = 16'h7000; cmd_valid = 1'b1;
        tick(); cmd_valid = 1'b0;
        check(prog_err && !cache_inval, "R9 command in invalidate cycle",
              int'({prog_err, cache_inval}), 2);
        tick(4);
        check(!busy && exp_q.size() == 0, "R9 collision not issued", int'(busy), 0);

        // R10: clear and set in same cycle, set wins
        exp_q.push_back({1'b0, 1'b0, 16'h8000});
        cmd_op = 1'b0; cmd_addr = 16'h8000; cmd_valid = 1'b1;
        tick(); cmd_valid = 1'b0;
        cmd_valid = 1'b1; err_clr = 1'b1; cmd_addr = 16'h9000;
        tick(); cmd_valid = 1'b0; err_clr = 1'b0;
        check(prog_err, "R10 set wins over clear", int'(prog_err), 1);
        wait_inval("R8 invalidate after write");
        tick();
        pulse_clr();

        // configuration B: 16 KB, 1 KB regions, no boot area, region 3 locked
        do_reset(2'd0, 4'd0);
        lock_bits = 16'h0008;
        do_cmd(1'b0, 16'h0C10, 1'b0, 16'h0, "R2 region 3 of 16 KB array locked");
        do_cmd(1'b0, 16'h0BFF, 1'b1, 16'h0BC0, "R2 region 2 of 16 KB array open");
        do_cmd(1'b0, 16'h4000, 1'b0, 16'h0, "R6 write past array end");
        do_cmd(1'b1, 16'h3FFF, 1'b1, 16'h3F00, "R6 last row accepted");

        // configuration C: code 3 treated as 64 KB, 4 KB regions
        do_reset(2'd3, 4'd0);
        lock_bits = 16'h0004;
        do_cmd(1'b1, 16'hF0AB, 1'b1, 16'hF000, "R2 code 3 reaches 64 KB");
        do_cmd(1'b0, 16'h2FC1, 1'b0, 16'h0, "R2 region 2 of 64 KB array locked");

        tick(3);
        check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule